// File: doc/BRIEF.md
# Serial Sync Pattern Matcher

This block watches a serial sync line made of a sync clock and a sync data wire, both coming from outside the chip's clock domain. It brings both wires into the system clock domain and detects rising edges of the synchronized sync clock. On each rising edge it shifts the synchronized data bit into a 16-bit sliding window. The window is compared against a programmed pattern. Each bit of a mask input removes the matching pattern bit from the comparison.

When the window matches, the block emits a single system-clock trigger pulse. That pulse starts a synchronized run: it moves the run sequencer out of its idle state into its initial-condition phase. The block then waits until it sees a window that does not match before it can fire again, so one match gives exactly one pulse. The matcher only works when a synchronized run mode (master or slave) is selected. With no sync mode selected it is held inactive and its window is held clear. A typical setting is pattern 0x550F with mask 0x0000, which checks all bits.

Top module: `sync_pattern_matcher`

## Requirements
- R1: After reset is released, `trigger_o` is 0, the window holds 0x0000 and the matcher is unarmed.
- R2: The window shifts only on a rising edge of the synchronized sync clock. The new bit enters bit 0 and older bits move toward bit 15, so the first of 16 received bits ends in bit 15. Falling edges do not shift the window.
- R3: A match exists when every window bit whose mask bit is 0 equals the same pattern bit. A mask bit of 1 excludes that bit from the comparison.
- R4: A trigger pulse is exactly one system clock cycle wide. It is high during the cycle that starts at the 4th rising system clock edge after the sync clock input rises on the edge that completes the match: 2 synchronizer stages, 1 shift register and 1 output register.
- R5: After a pulse, no further pulse is produced until the window has been seen not matching. A window that slides out of the match and back into it produces a new pulse.
- R6: While `sync_en_i` is 0, `trigger_o` stays 0 and the window and arming state are held clear. After enabling, a complete matching pattern must be received before a pulse can occur.
- R7: Changes on `sync_data_i` while the sync clock is not rising have no effect on the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_en_i | input | 1 | 1 when a synchronized run mode (master or slave) is selected |
| sync_clk_i | input | 1 | Asynchronous serial sync clock |
| sync_data_i | input | 1 | Asynchronous serial sync data |
| pattern_i | input | 16 | Compare pattern |
| mask_i | input | 16 | Per-bit ignore mask, 1 = ignore |
| trigger_o | output | 1 | One-cycle start trigger |

## Verification
The bench sends the pattern in the reverse bit order; a design that shifted the wrong way would trigger there and stay silent on the correct order. A fully masked compare is held for many sync edges; a design without arming would then pulse on every cycle or every edge, instead of once. The bench slides a window out of a match and back into it; a design that never re-arms would miss the second pulse. It also sends a full pattern while disabled and then enables; a design that kept shifting while disabled would fire on stale bits. Data glitches are injected while the sync clock is steady, which catches a window that samples data off-edge. The exact latency of the pulse is measured on the completing edge.

// File: rtl/sync_pm_pkg.sv
package sync_pm_pkg;
    localparam int unsigned WIN_W       = 16;
    localparam int unsigned SYNC_STAGES = 2;

    typedef struct packed {
        logic             prev_clk;
        logic             shift;
        logic [WIN_W-1:0] win;
    } win_state_t;

    typedef struct packed {
        logic armed;
        logic trig;
    } cmp_state_t;
endpackage

// File: rtl/sync_pm_sync.sv
module sync_pm_sync #(
    parameter int unsigned W      = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= async_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/sync_pm_window.sv
module sync_pm_window
    import sync_pm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             sclk_i,
    input  logic             sdata_i,
    output logic [WIN_W-1:0] win_o,
    output logic             shift_o
);
    win_state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.prev_clk = sclk_i;
        st_d.shift    = sclk_i & ~st_q.prev_clk;
        if (!en_i) begin
            st_d.win = '0;
        end else if (sclk_i && !st_q.prev_clk) begin
            st_d.win = {st_q.win[WIN_W-2:0], sdata_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign win_o   = st_q.win;
    assign shift_o = st_q.shift;
endmodule

// File: rtl/sync_pm_compare.sv
module sync_pm_compare
    import sync_pm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [WIN_W-1:0] win_i,
    input  logic [WIN_W-1:0] pattern_i,
    input  logic [WIN_W-1:0] mask_i,
    output logic             match_o,
    output logic             trig_o
);
    cmp_state_t st_d, st_q;
    logic       hit;

    always_comb begin
        hit        = ((win_i ^ pattern_i) & ~mask_i) == '0;
        st_d       = st_q;
        st_d.trig  = en_i & hit & st_q.armed;
        if (!en_i)              st_d.armed = 1'b0;
        else if (st_d.trig)     st_d.armed = 1'b0;
        else if (!hit)          st_d.armed = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign match_o = hit;
    assign trig_o  = st_q.trig;
endmodule

// File: rtl/sync_pattern_matcher.sv
module sync_pattern_matcher
    import sync_pm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_en_i,
    input  logic             sync_clk_i,
    input  logic             sync_data_i,
    input  logic [WIN_W-1:0] pattern_i,
    input  logic [WIN_W-1:0] mask_i,
    output logic             trigger_o
);
    logic [1:0]       synced;
    logic [WIN_W-1:0] window;
    logic             shift_seen;
    logic             match;

    sync_pm_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sync_clk_i, sync_data_i}),
        .sync_o  (synced)
    );

    sync_pm_window u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (sync_en_i),
        .sclk_i  (synced[1]),
        .sdata_i (synced[0]),
        .win_o   (window),
        .shift_o (shift_seen)
    );

    sync_pm_compare u_compare (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (sync_en_i),
        .win_i     (window),
        .pattern_i (pattern_i),
        .mask_i    (mask_i),
        .match_o   (match),
        .trig_o    (trigger_o)
    );
endmodule

// File: rtl/sync_pattern_matcher_chk.sv
module sync_pattern_matcher_chk
    import sync_pm_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             sync_en_i,
    input logic             trigger_o,
    input logic             match,
    input logic             shift_seen,
    input logic [1:0]       synced,
    input logic [WIN_W-1:0] window
);
    // R4: pulse is one cycle wide
    p_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trigger_o |=> !trigger_o);

    // R6: disabled matcher never triggers
    p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_en_i |=> !trigger_o);

    // R3: a trigger follows a cycle in which the compare matched
    p_trig_needs_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trigger_o) |-> $past(match));

    // R2, R7: without a sync clock rise the window holds
    p_window_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_en_i && !(synced[1] && !shift_seen && $changed(synced[1]))) |=> $stable(window) || $past(synced[1]) );

    // R6: window clear while disabled
    p_window_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_en_i |=> window == '0);
endmodule

bind sync_pattern_matcher sync_pattern_matcher_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_en_i  (sync_en_i),
    .trigger_o  (trigger_o),
    .match      (match),
    .shift_seen (shift_seen),
    .synced     (synced),
    .window     (window)
);

// File: tb/sync_pattern_matcher_bench.sv
module sync_pattern_matcher_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sync_en_i = 1'b0;
    logic        sync_clk_i = 1'b0;
    logic        sync_data_i = 1'b0;
    logic [15:0] pattern_i = 16'h550F;
    logic [15:0] mask_i = 16'h0000;
    logic        trigger_o;

    int tests = 0;
    int fails = 0;
    int pulses = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sync_pattern_matcher u_sync_pattern_matcher (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_en_i   (sync_en_i),
        .sync_clk_i  (sync_clk_i),
        .sync_data_i (sync_data_i),
        .pattern_i   (pattern_i),
        .mask_i      (mask_i),
        .trigger_o   (trigger_o)
    );

    always @(negedge clk) if (trigger_o) pulses++;

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [15:0] pat, input logic [15:0] msk);
        @(negedge clk);
        rst_n = 1'b0; sync_clk_i = 1'b0; sync_data_i = 1'b0;
        pattern_i = pat; mask_i = msk; sync_en_i = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        pulses = 0;
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk) sync_data_i = b;
        @(negedge clk) sync_clk_i = 1'b1;
        repeat (3) @(negedge clk);
        sync_clk_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_word(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) send_bit(w[i]);
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 trigger in reset", trigger_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 trigger after reset", trigger_o, 0);
    endtask

    task automatic t_latency;
        do_reset(16'h550F, 16'h0000);
        for (int i = 15; i >= 1; i--) send_bit(1'b0 ^ ((16'h550F >> i) & 1));
        @(negedge clk) sync_data_i = 1'b1;
        @(negedge clk) sync_clk_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R4 no pulse before latency", trigger_o, 0);
        @(negedge clk);
        check("R4 pulse at 4th edge", trigger_o, 1);
        @(negedge clk);
        check("R4 pulse one cycle", trigger_o, 0);
        sync_clk_i = 1'b0;
        repeat (8) @(negedge clk);
        check("R3 default pattern pulse count", pulses, 1);
    endtask

    task automatic t_mismatch;
        do_reset(16'h550F, 16'h0000);
        send_word(16'h550E);
        check("R3 one-bit mismatch", pulses, 0);
    endtask

    task automatic t_masked;
        do_reset(16'h550F, 16'h00FF);
        send_word(16'h55A3);
        check("R3 masked low byte match", pulses, 1);
    endtask

    task automatic t_order;
        do_reset(16'h550F, 16'h0000);
        send_word(16'hF0AA);
        check("R2 reversed order no match", pulses, 0);
    endtask

    task automatic t_full_mask;
        do_reset(16'h550F, 16'h0000);
        @(negedge clk) mask_i = 16'hFFFF;
        repeat (5) @(negedge clk);
        for (int i = 0; i < 5; i++) send_bit(i[0]);
        repeat (5) @(negedge clk);
        check("R5 full mask single pulse", pulses, 1);
    endtask

    task automatic t_rearm;
        do_reset(16'h5555, 16'h0000);
        send_word(16'h5555);
        check("R5 first match", pulses, 1);
        send_bit(1'b0);
        send_bit(1'b1);
        repeat (6) @(negedge clk);
        check("R5 rearm after slide", pulses, 2);
    endtask

    task automatic t_disable;
        do_reset(16'h550F, 16'h0000);
        @(negedge clk) sync_en_i = 1'b0;
        send_word(16'h550F);
        check("R6 disabled no pulse", pulses, 0);
        @(negedge clk) sync_en_i = 1'b1;
        repeat (10) @(negedge clk);
        check("R6 enable no stale pulse", pulses, 0);
        send_bit(1'b1);
        check("R6 window cleared while disabled", pulses, 0);
        send_word(16'h550F);
        check("R6 match after enable", pulses, 1);
    endtask

    task automatic t_glitch;
        do_reset(16'h550F, 16'h0000);
        for (int i = 15; i >= 0; i--) begin
            logic b;
            b = (16'h550F >> i) & 1;
            @(negedge clk) sync_data_i = ~b;
            @(negedge clk) sync_data_i = b;
            @(negedge clk) sync_clk_i = 1'b1;
            repeat (3) @(negedge clk);
            sync_data_i = ~b;
            repeat (2) @(negedge clk);
            sync_clk_i = 1'b0;
            repeat (3) @(negedge clk);
            sync_data_i = b;
        end
        repeat (6) @(negedge clk);
        check("R7 glitches ignored", pulses, 1);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_latency();
        t_mismatch();
        t_masked();
        t_order();
        t_full_mask();
        t_rearm();
        t_disable();
        t_glitch();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule